// File: doc/BRIEF.md
# Configuration Clock Burst Counter

This block drives a fixed number of clock pulses toward a device configuration port when software asks for them. Software writes a pulse count into the count register. The block then toggles a gated pulse output once per counted pulse: high for one cycle, low for the next. When the last low phase ends, a sticky completion flag rises.

The flag stays set until software writes a one to its bit. A typical use comes after the configuration data stream has been switched off: software clears any stale completion, writes a count of four, and polls the status register until the flag appears. It then writes a one to the flag to acknowledge it.

Software can also write a new count while a burst is still running. The burst restarts with the new value and the flag is cleared. A count of zero produces no pulses and completes on the next cycle. Reading the count register returns the number of pulses still owed.

Top module: `cfg_clk_burst`

## Requirements
- R1: A write of N>0 to the count register (word address 0) gives exactly N pulses on `pulse_o`. The first high cycle is the cycle after the write edge, and each high cycle is followed by exactly one low cycle.
- R2: Bit 0 of the status register (word address 1), also driven on `done_o`, becomes 1 in the cycle that follows the last low phase, 2N cycles after the write edge.
- R3: The done flag is sticky. A status write whose bit 0 is 0 leaves it unchanged.
- R4: A status write whose bit 0 is 1 clears the done flag on the next edge.
- R5: A count write of zero produces no pulse and sets the done flag one cycle after the write edge.
- R6: A count write during a burst restarts it with the new value and clears the done flag. The old remaining count is discarded.
- R7: Reading the count register returns the pulses whose high phase has not yet ended. The value drops by one after each high cycle and reads 0 once the burst has finished.
- R8: When completion and a clearing status write fall in the same cycle, the flag ends up set.
- R9: After reset `pulse_o` and `done_o` are 0, and both registers read 0.
- R10: Writes to word addresses 2 and 3 have no effect, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address: 0 count, 1 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pulse_o | output | 1 | Gated configuration clock pulse |
| done_o | output | 1 | Sticky burst-complete flag |

## Verification
Two events can fall in the same cycle: a burst finishing, and software clearing the flag. The bench starts a one-pulse burst and presents the clearing status write in exactly the cycle in which the final low phase ends. It judges that the flag reads 1 afterwards, so the completion is not lost.

The same rule for start versus finish is covered by restarting a burst in the middle and checking that the flag stays 0 until the new count has been fully delivered.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
    // Word addresses seen on the register bus
    localparam int unsigned ADDR_W = 2;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 2'd1;
    // Bit of the status word that holds the completion flag
    localparam int unsigned DONE_BIT = 0;
endpackage

// File: rtl/cbc_regif.sv
// Register decode: turns bus writes into start/clear requests and muxes reads.
module cbc_regif
    import cbc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  rem_cnt,
    input  logic              done_flag,
    output logic              start_req,
    output logic [CNT_W-1:0]  start_cnt,
    output logic              clr_req,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned PAD_W = DATA_W - CNT_W;

    always_comb begin
        start_req = wr && (addr == OFS_COUNT);
        start_cnt = wdata[CNT_W-1:0];
        clr_req   = wr && (addr == OFS_STATUS) && wdata[DONE_BIT];
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_COUNT:  rdata = {{PAD_W{1'b0}}, rem_cnt};
            OFS_STATUS: rdata[DONE_BIT] = done_flag;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/cbc_engine.sv
// Burst engine: counts pulses down, one high and one low cycle per pulse.
module cbc_engine #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [CNT_W-1:0] start_cnt,
    output logic [CNT_W-1:0] rem_cnt,
    output logic             pulse,
    output logic             finish
);
    typedef struct packed {
        logic [CNT_W-1:0] rem;
        logic             hi;
        logic             busy;
    } eng_t;

    eng_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        finish = 1'b0;
        if (st_q.busy) begin
            if (st_q.hi) begin
                st_d.hi  = 1'b0;
                st_d.rem = st_q.rem - CNT_W'(1);
            end else if (st_q.rem == '0) begin
                st_d.busy = 1'b0;
                finish    = 1'b1;
            end else begin
                st_d.hi = 1'b1;
            end
        end
        if (start_req) begin
            st_d.rem  = start_cnt;
            st_d.hi   = (start_cnt != '0);
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rem_cnt = st_q.rem;
    assign pulse   = st_q.hi;

    p_high_then_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pulse && !start_req |=> !pulse);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> !pulse);
    p_rem_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse && !start_req |=> rem_cnt == $past(rem_cnt) - CNT_W'(1));
    p_zero_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_req && start_cnt == '0 |=> finish && !pulse);
endmodule

// File: rtl/cbc_done.sv
// Sticky completion flag with write-one-to-clear.
module cbc_done (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic finish,
    input  logic clr_req,
    output logic done
);
    typedef struct packed {
        logic flag;
    } done_t;

    done_t dn_d, dn_q;

    always_comb begin
        dn_d = dn_q;
        if (clr_req)   dn_d.flag = 1'b0;
        if (finish)    dn_d.flag = 1'b1;
        if (start_req) dn_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dn_q <= '0;
        else        dn_q <= dn_d;
    end

    assign done = dn_q.flag;

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done && !clr_req && !start_req |=> done);
    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req && !finish && !start_req |=> !done);
    p_restart_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> !done);
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        finish && !start_req |=> done);
endmodule

// File: rtl/cfg_clk_burst.sv
module cfg_clk_burst
    import cbc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pulse_o,
    output logic              done_o
);
    logic             start_req;
    logic [CNT_W-1:0] start_cnt;
    logic             clr_req;
    logic [CNT_W-1:0] rem_cnt;
    logic             finish;

    cbc_regif #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regif (
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rem_cnt   (rem_cnt),
        .done_flag (done_o),
        .start_req (start_req),
        .start_cnt (start_cnt),
        .clr_req   (clr_req),
        .rdata     (bus_rdata)
    );

    cbc_engine #(.CNT_W(CNT_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .start_cnt (start_cnt),
        .rem_cnt   (rem_cnt),
        .pulse     (pulse_o),
        .finish    (finish)
    );

    cbc_done u_done (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .finish    (finish),
        .clr_req   (clr_req),
        .done      (done_o)
    );

    // R10: unused offsets neither start a burst nor clear the flag
    p_unused_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr[1] |-> !start_req && !clr_req);
endmodule

// File: tb/cfg_clk_burst_tb.sv
module cfg_clk_burst_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pulse_o;
    logic        done_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    cfg_clk_burst u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pulse_o   (pulse_o),
        .done_o    (done_o)
    );

    localparam int VEC_N = 6;
    localparam int VEC_CNT [VEC_N] = '{4, 1, 3, 0, 7, 2};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Ends at the negedge one cycle after the capturing edge
    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 2'd0;
    endtask

    // Called at the negedge right after the count-write edge (sample 1)
    task automatic observe(input int n, input string req);
        int pulses = 0;
        int bad = 0;
        int done_at = 0;
        int exp_done = (n == 0) ? 2 : 2 * n + 1;
        for (int i = 1; i <= 2 * n + 6; i++) begin
            #1;
            if (pulse_o) begin
                pulses++;
                if ((i % 2) == 0 || i > 2 * n) bad++;
            end else if ((i % 2) == 1 && i <= 2 * n) begin
                bad++;
            end
            if (done_o && done_at == 0) done_at = i;
            @(negedge clk);
        end
        chk({req, " R1 pulse count"}, pulses, n);
        chk({req, " R1 pulse shape errors"}, bad, 0);
        chk({req, " R2/R5 done sample"}, done_at, exp_done);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        #1;
        // R9: reset state
        chk("R9 pulse", int'(pulse_o), 0);
        chk("R9 done", int'(done_o), 0);
        bus_read(2'd0, rd); chk("R9 count read", int'(rd), 0);
        bus_read(2'd1, rd); chk("R9 status read", int'(rd), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table of bursts: clear stale flag first, then issue count
        for (int v = 0; v < VEC_N; v++) begin
            bus_write(2'd1, 32'h1);
            chk("R4 pre-clear", int'(done_o), 0);
            bus_write(2'd0, 32'(VEC_CNT[v]));
            observe(VEC_CNT[v], $sformatf("vec%0d", v));
            bus_read(2'd1, rd); chk("R2 status bit0", int'(rd[0]), 1);
            bus_read(2'd0, rd); chk("R7 count after finish", int'(rd), 0);
        end

        // R3 sticky: write 0 to status, wait
        bus_write(2'd1, 32'h0);
        repeat (4) @(negedge clk);
        #1; chk("R3 sticky after write 0", int'(done_o), 1);
        // R4 clear
        bus_write(2'd1, 32'h1);
        #1; chk("R4 cleared", int'(done_o), 0);

        // R7 readback during a burst of 5
        @(negedge clk);
        bus_write(2'd0, 32'd5);
        bus_read(2'd0, rd); chk("R7 read sample1", int'(rd), 5);
        @(negedge clk);
        bus_read(2'd0, rd); chk("R7 read sample2", int'(rd), 4);
        @(negedge clk);
        bus_read(2'd0, rd); chk("R7 read sample3", int'(rd), 4);
        @(negedge clk);
        bus_read(2'd0, rd); chk("R7 read sample4", int'(rd), 3);
        repeat (10) @(negedge clk);
        #1; chk("R2 done after 5", int'(done_o), 1);

        // R6 restart mid-burst (flag set beforehand)
        bus_write(2'd0, 32'd6);
        repeat (3) @(negedge clk);
        bus_write(2'd0, 32'd2);
        #1; chk("R6 done cleared", int'(done_o), 0);
        observe(2, "R6 restart");

        // R8 finish and clear in the same cycle
        bus_write(2'd0, 32'd1);       // sample 1
        bus_write(2'd1, 32'h1);       // presented in sample 2, the finish cycle
        #1; chk("R8 set wins", int'(done_o), 1);
        @(negedge clk);
        #1; chk("R8 still set", int'(done_o), 1);

        // R10 unused addresses
        bus_write(2'd2, 32'hFFFF_FFFF);
        bus_write(2'd3, 32'hFFFF_FFFF);
        repeat (2) @(negedge clk);
        #1;
        chk("R10 done unchanged", int'(done_o), 1);
        chk("R10 no pulse", int'(pulse_o), 0);
        bus_read(2'd2, rd); chk("R10 read addr2", int'(rd), 0);
        bus_read(2'd3, rd); chk("R10 read addr3", int'(rd), 0);
        bus_read(2'd0, rd); chk("R10 count untouched", int'(rd), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule